// File: doc/BRIEF.md
# Paged I2C Register Target

This block is an I2C target that exposes a small file of 8-bit registers to a host. The file is split into pages of equal size. Register 0 is the page selector and is visible at the same offset on every page. Register 1 carries a self-clearing soft-reset bit. All other offsets hold ordinary storage for the page that is currently selected. The bus is oversampled on the system clock. Both lines pass through a two-flop synchroniser. START and STOP are detected outside the byte state machine and override it at any time.

A write transfer works as follows. The first data byte after the address loads the register pointer. Each later byte is stored at the pointer, and the pointer then advances. A read returns the byte at the pointer. Each master ACK advances the pointer and sends the next byte. The pointer stops at the last register of the page and never wraps onto another page. A strap pin picks one of two fixed 7-bit device addresses.

The byte engine has seven states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte. On the eighth falling SCL edge it moves to `ST_ADDR_ACK` on an address match, or back to `ST_IDLE` otherwise.
- `ST_ADDR_ACK`: drives the ACK. On the next falling edge it moves to `ST_RD_BYTE` when the R/W bit is 1, or to `ST_WR_BYTE` when it is 0.
- `ST_WR_BYTE`: goes to `ST_WR_ACK` after eight bits, committing the byte on that same edge.
- `ST_WR_ACK`: returns to `ST_WR_BYTE`.
- `ST_RD_BYTE`: goes to `ST_RD_ACK` after its eighth bit.
- `ST_RD_ACK`: returns to `ST_RD_BYTE` on a master ACK, or to `ST_IDLE` on a NACK.

A STOP from any state goes to `ST_IDLE`. A START from any state goes to `ST_ADDR`.

Top module: `i2c_paged_regs`

## Requirements
- R1: With `addr_sel` low the device answers address 7'h18; with it high it answers 7'h1A. A matching address is ACKed (SDA pulled low in the ninth clock). Any other address is NACKed, and the following bytes are neither ACKed nor stored until the next START.
- R2: In a write transfer the first data byte loads the register pointer. A value above the last register index (REGS-1) loads REGS-1.
- R3: Each later data byte of a write is stored at the pointer and ACKed, after which the pointer advances by one.
- R4: A read returns the register at the pointer, MSB first. A master ACK advances the pointer and sends the next register. A master NACK ends the read and SDA is released.
- R5: Pointer advance saturates at register REGS-1 of the page, for reads and writes alike. Extra writes overwrite that last register, and extra reads repeat it.
- R6: Register 0 selects the page on every page. Only its low $clog2(PAGES) bits are writable; the other bits read 0. Registers 2 and up belong to the selected page.
- R7: Writing a byte with bit 7 set to register 1 restores every register to its default and selects page 0. Register 1 always reads 8'h00, and its other bits ignore writes.
- R8: The default of register r (r >= 2) on page p is {p[3:0], r[3:0]}.
- R9: A STOP at any point returns the engine to idle with SDA released. A repeated START restarts the address phase.
- R10: After reset SDA is released, page 0 is selected and all registers hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap choosing between the two device addresses |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Pointer saturation is checked by writing three bytes starting at register 6 and then reading three bytes back. A design that wrapped or crossed into the next page would show the wrong bytes, or would corrupt register 0 and switch pages. The soft reset is checked after both pages have been modified. A design that failed to clear the page selector, or that kept register 1 bit 7 set, reads back non-default values. The address strap is tested in both positions, each against the other address. A design with a loose compare would ACK a foreign transfer and store its bytes. Clamping of out-of-range pointers and release of SDA after a read NACK are checked directly at the port.

// File: rtl/i2c_preg_pkg.sv
package i2c_preg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } i2c_state_e;

    // Power-on value of register r on page p (offsets 0 and 1 are special)
    function automatic logic [7:0] reg_default(input int p, input int r);
        return {4'(p), 4'(r)};
    endfunction

endpackage

// File: rtl/i2c_preg_sync.sv
module i2c_preg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_pipe;
    logic [2:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= 3'b111;
            sda_pipe <= 3'b111;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_in};
            sda_pipe <= {sda_pipe[1:0], sda_in};
        end
    end

    // bit 1 = current synchronised level, bit 2 = previous level
    assign scl_lvl   = scl_pipe[1];
    assign sda_lvl   = sda_pipe[1];
    assign scl_rise  = scl_pipe[1] & ~scl_pipe[2];
    assign scl_fall  = ~scl_pipe[1] & scl_pipe[2];
    assign start_det = scl_pipe[1] & scl_pipe[2] & sda_pipe[2] & ~sda_pipe[1];
    assign stop_det  = scl_pipe[1] & scl_pipe[2] & ~sda_pipe[2] & sda_pipe[1];
endmodule

// File: rtl/i2c_preg_file.sv
module i2c_preg_file #(
    parameter int PAGES = 2,
    parameter int REGS  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(REGS)-1:0] waddr,
    input  logic [7:0]              wdata,
    input  logic [$clog2(REGS)-1:0] raddr,
    output logic [7:0]              rdata
);
    import i2c_preg_pkg::*;

    localparam int AW = $clog2(REGS);
    localparam int PW = $clog2(PAGES);

    logic [PW-1:0] page_q;
    logic [7:0]    mem [PAGES][REGS];
    logic          soft_rst;

    assign soft_rst = we && (waddr == AW'(1)) && wdata[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (soft_rst) begin
            page_q <= '0;
        end else if (we && waddr == '0) begin
            page_q <= wdata[PW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++)
                for (int r = 0; r < REGS; r++)
                    mem[p][r] <= reg_default(p, r);
        end else if (soft_rst) begin
            for (int p = 0; p < PAGES; p++)
                for (int r = 0; r < REGS; r++)
                    mem[p][r] <= reg_default(p, r);
        end else if (we && waddr > AW'(1)) begin
            mem[page_q][waddr] <= wdata;
        end
    end

    always_comb begin
        if (raddr == '0)
            rdata = 8'(page_q);
        else if (raddr == AW'(1))
            rdata = 8'h00;
        else
            rdata = mem[page_q][raddr];
    end

    p_soft_reset_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (page_q == '0));

    p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(page_q));
endmodule

// File: rtl/i2c_paged_regs.sv
module i2c_paged_regs #(
    parameter int         PAGES   = 2,
    parameter int         REGS    = 8,
    parameter logic [6:0] ADDR_LO = 7'h18,
    parameter logic [6:0] ADDR_HI = 7'h1A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_sel,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    import i2c_preg_pkg::*;

    localparam int          AW   = $clog2(REGS);
    localparam logic [AW-1:0] LAST = AW'(REGS - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_preg_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_state_e    state_q, state_d;
    logic [3:0]    bit_cnt;
    logic [7:0]    shift_q;
    logic          rw_q, first_q, mack_q;
    logic [AW-1:0] ptr_q, ptr_inc;
    logic [7:0]    rdata;
    logic          addr_hit, byte_done, reg_we;

    assign addr_hit  = (shift_q[7:1] == (addr_sel ? ADDR_HI : ADDR_LO));
    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign ptr_inc   = (ptr_q == LAST) ? LAST : ptr_q + 1'b1;
    assign reg_we    = (state_q == ST_WR_BYTE) && byte_done && !first_q;

    i2c_preg_file #(.PAGES(PAGES), .REGS(REGS)) u_file (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .waddr(ptr_q),
        .wdata(shift_q),
        .raddr(ptr_q),
        .rdata(rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt == 4'd7) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = mack_q ? ST_RD_BYTE : ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: shifter, bit counter, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shift_q <= '0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            mack_q  <= 1'b0;
            ptr_q   <= '0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shift_q <= {shift_q[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (state_q == ST_ADDR) begin
                            rw_q    <= shift_q[0];
                            first_q <= 1'b1;
                        end else if (first_q) begin
                            ptr_q   <= (shift_q > 8'(LAST)) ? LAST : shift_q[AW-1:0];
                            first_q <= 1'b0;
                        end else begin
                            ptr_q <= ptr_inc;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) shift_q <= rdata;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) bit_cnt <= '0;
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 4'd1;
                            shift_q <= {shift_q[6:0], 1'b0};
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_q <= !sda_lvl;
                        if (!sda_lvl) ptr_q <= ptr_inc;
                    end else if (scl_fall) begin
                        shift_q <= rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // output register: SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
        end else if (start_det || stop_det) begin
            sda_oe <= 1'b0;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_ADDR:     sda_oe <= (bit_cnt == 4'd8) && addr_hit;
                ST_ADDR_ACK: sda_oe <= rw_q && !rdata[7];
                ST_WR_BYTE:  sda_oe <= (bit_cnt == 4'd8);
                ST_WR_ACK:   sda_oe <= 1'b0;
                ST_RD_BYTE:  sda_oe <= (bit_cnt != 4'd7) && !shift_q[6];
                ST_RD_ACK:   sda_oe <= mack_q && !rdata[7];
                default:     sda_oe <= 1'b0;
            endcase
        end
    end

    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);

    p_stop_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE));

    p_ptr_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WR_BYTE && ptr_q == LAST) |=> (ptr_q == LAST));

    p_sda_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && !start_det && !stop_det) |=> $stable(sda_oe));

    p_nack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACK && scl_fall && !mack_q && !start_det && !stop_det)
        |=> (!sda_oe && state_q == ST_IDLE));
endmodule

// File: tb/i2c_paged_regs_tb.sv
module i2c_paged_regs_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   n_tests = 0;
    int   n_fail = 0;
    logic done = 1'b0;

    assign sda_bus = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_paged_regs u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_sel(addr_sel),
        .scl_in  (m_scl),
        .sda_in  (sda_bus),
        .sda_oe  (sda_oe)
    );

    // {pointer, data written, value expected on read-back}
    localparam logic [23:0] VEC [8] = '{
        {8'd2, 8'hA5, 8'hA5},   // R3 plain storage
        {8'd3, 8'h3C, 8'h3C},   // R3
        {8'd7, 8'hFF, 8'hFF},   // R3 last register
        {8'd1, 8'h7F, 8'h00},   // R7 reserved bits ignore writes
        {8'd0, 8'hFF, 8'h01},   // R6 only page bit kept -> page 1
        {8'd2, 8'h5A, 8'h5A},   // R6 page 1 storage
        {8'd3, 8'h00, 8'h00},   // R6
        {8'd0, 8'hFE, 8'h00}    // R6 back to page 0
    };

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(2 * Q);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        ack = ~sda_bus; wq(Q);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(Q);
            m_scl = 1'b1; wq(Q);
            d[i] = sda_bus; wq(Q);
            m_scl = 1'b0;
        end
        m_sda = ~give_ack; wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_scl = 1'b0;
    endtask

    function automatic logic [7:0] dev_byte(input logic rd);
        return {(addr_sel ? 7'h1A : 7'h18), rd};
    endfunction

    task automatic wr_seq(input logic [7:0] ptr, input logic [7:0] d0, input int n, input string tag);
        logic a;
        i2c_start();
        send_byte(dev_byte(1'b0), a); chk({tag, " addr ack"}, 8'(a), 8'h01);
        send_byte(ptr, a);
        for (int k = 0; k < n; k++) begin
            send_byte(d0 + 8'(k * 8'h11), a);
        end
        chk({tag, " data ack"}, 8'(a), 8'h01);
        i2c_stop();
    endtask

    task automatic rd_one(input logic [7:0] ptr, output logic [7:0] d);
        logic a;
        i2c_start();
        send_byte(dev_byte(1'b0), a);
        send_byte(ptr, a);
        i2c_start();   // repeated START (R9)
        send_byte(dev_byte(1'b1), a);
        recv_byte(1'b0, d);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic a;
        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R10 reset state
        chk("R10 sda released", 8'(sda_oe), 8'h00);
        rd_one(8'd0, d); chk("R10 page 0", d, 8'h00);
        rd_one(8'd2, d); chk("R10/R8 default p0r2", d, 8'h02);

        // table walk: single write, then read back
        foreach (VEC[i]) begin
            wr_seq(VEC[i][23:16], VEC[i][15:8], 1, "R3 table");
            rd_one(VEC[i][23:16], d);
            chk($sformatf("R3/R6/R7 table entry %0d", i), d, VEC[i][7:0]);
        end
        rd_one(8'd2, d); chk("R6 page 0 kept A5", d, 8'hA5);

        // R1 wrong address NACKed, bytes ignored
        i2c_start();
        send_byte({7'h1A, 1'b0}, a); chk("R1 foreign addr nack", 8'(a), 8'h00);
        send_byte(8'd2, a);          chk("R1 no ack after nack", 8'(a), 8'h00);
        send_byte(8'h99, a);
        i2c_stop();
        rd_one(8'd2, d); chk("R1 reg untouched", d, 8'hA5);

        // R1 strap high
        addr_sel = 1'b1;
        rd_one(8'd2, d); chk("R1 strap high addr", d, 8'hA5);
        i2c_start();
        send_byte({7'h18, 1'b0}, a); chk("R1 low addr nack when strapped high", 8'(a), 8'h00);
        i2c_stop();
        addr_sel = 1'b0;

        // R2 pointer clamp
        wr_seq(8'h40, 8'h77, 1, "R2 clamp");
        rd_one(8'd7, d); chk("R2 clamp lands on last", d, 8'h77);

        // R5 sequential write saturates: 11->r6, 22->r7, 33->r7
        wr_seq(8'd6, 8'h11, 3, "R5 seq wr");
        rd_one(8'd0, d); chk("R5 page not disturbed", d, 8'h00);

        // R4/R5 sequential read 6,7,7 then NACK release
        i2c_start();
        send_byte(dev_byte(1'b0), a);
        send_byte(8'd6, a);
        i2c_start();
        send_byte(dev_byte(1'b1), a);
        recv_byte(1'b1, d); chk("R4 seq rd r6", d, 8'h11);
        recv_byte(1'b1, d); chk("R5 seq rd r7", d, 8'h33);
        recv_byte(1'b0, d); chk("R5 seq rd saturate", d, 8'h33);
        wq(Q);
        chk("R4 nack releases sda", 8'(sda_oe), 8'h00);
        i2c_stop();
        wq(Q);
        chk("R9 stop releases sda", 8'(sda_oe), 8'h00);

        // R7 soft reset after touching page 1
        wr_seq(8'd0, 8'h01, 1, "R7 prep");
        wr_seq(8'd4, 8'hC3, 1, "R7 prep");
        wr_seq(8'd1, 8'h80, 1, "R7 reset");
        rd_one(8'd0, d); chk("R7 page back to 0", d, 8'h00);
        rd_one(8'd1, d); chk("R7 bit self-clears", d, 8'h00);
        rd_one(8'd2, d); chk("R7 p0r2 default", d, 8'h02);
        rd_one(8'd7, d); chk("R7 p0r7 default", d, 8'h07);
        wr_seq(8'd0, 8'h01, 1, "R8 page");
        rd_one(8'd4, d); chk("R8 p1r4 default", d, 8'h14);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule